// File: doc/BRIEF.md
# Strobe-Handshake Host Register Port

A slave-side register port that lets a host processor reach two identical banks of 16-bit registers through an asynchronous, active-low strobe bus. The host drives an active-low chip select, a bank-select line, separate active-low read and write strobes, a 10-bit address and a 16-bit data bus. The block answers with a ready handshake that is modelled as an open-drain output enable: asserted means the line is pulled to 0, released means high impedance.

Both strobes cross into the core clock through two-flop synchronisers. When the synchronised strobe is first seen, the block captures the address, chip select, bank select and write data. It uses that snapshot for the whole access. It then performs one read or write on the selected bank and raises ready. Ready stays up until the active strobe is seen released. The read data bus is driven only while the read is being answered and both the chip select and the read strobe are low. A new access starts only after both strobes have been seen high.

Top module: `hreg_strobe_port`

## Requirements
- R1: After reset, `rdy_oe_o` and `data_oe_o` are 0, and every register in both banks reads as 0x0000.
- R2: `port_sel_i` high steers the access to bank 1 and low steers it to bank 0. The two banks hold independent contents at the same address.
- R3: A write with `cs_ni` low stores `data_i` at the captured address of the captured bank, then asserts `rdy_oe_o`. A later read of that location returns the stored value.
- R4: On a read, `rdy_oe_o` rises together with `data_oe_o`, and `data_o` already carries the addressed register value. `data_oe_o` is never high while `rdy_oe_o` is low.
- R5: An access made with `cs_ni` high writes nothing and never asserts `rdy_oe_o`.
- R6: If both strobes are low at once, the access is ignored: no register changes and `rdy_oe_o` stays 0.
- R7: `rdy_oe_o` stays asserted while the active strobe is held low. It is released within 6 core cycles after that strobe rises. It rises only at the end of an accepted access.
- R8: `data_oe_o` falls in the same instant that `rd_ni` or `cs_ni` goes high.
- R9: Address, bank select and write data are sampled once per access. Changing `addr_i` or `port_sel_i` after ready has risen does not alter the read data shown or the location written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| port_sel_i | input | 1 | Bank select: 1 selects bank 1, 0 selects bank 0 |
| rd_ni | input | 1 | Read strobe, active low, asynchronous |
| wr_ni | input | 1 | Write strobe, active low, asynchronous |
| addr_i | input | 10 | Register address |
| data_i | input | 16 | Write data from the host bus |
| data_o | output | 16 | Read data toward the host bus |
| data_oe_o | output | 1 | Enable of the data bus driver |
| rdy_oe_o | output | 1 | Ready pull-down enable (1 pulls the line to 0) |

## Verification
The checker watches every cycle for these properties: the data driver is enabled only inside the ready window, ready stays up while the active synchronised strobe is held, ready rises only from the access state, a strobe collision seen in idle never yields ready, and at most one bank is written per cycle. Data correctness cannot be checked cycle by cycle and is shown only by the bench scenarios. These cover read-after-write on both banks, the isolation of the two banks, the rejection of deselected and colliding accesses, the immediacy of the bus release, and the insensitivity to address changes after capture. The strobes in these scenarios arrive at random sub-cycle phases.

// File: rtl/hreg_pkg.sv
package hreg_pkg;
  localparam int unsigned NUM_BANKS = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACT   = 2'd1,
    ST_HOLD  = 2'd2,
    ST_DRAIN = 2'd3
  } hs_state_e;
endpackage

// File: rtl/hreg_sync2.sv
module hreg_sync2 #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/hreg_bank.sv
module hreg_bank #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/hreg_hs_ctrl.sv
module hreg_hs_ctrl
  import hreg_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_s_i,
  input  logic              wr_s_i,
  input  logic              cs_ni,
  input  logic              port_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output hs_state_e         state_o,
  output logic              is_wr_o,
  output logic              port_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              we_o,
  output logic              re_o,
  output logic              rdy_o
);
  hs_state_e         state_q, state_d;
  logic              is_wr_q, port_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              capture;
  logic              active_s;

  assign capture  = (state_q == ST_IDLE) && (rd_s_i ^ wr_s_i);
  assign active_s = is_wr_q ? wr_s_i : rd_s_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (rd_s_i && wr_s_i) state_d = ST_DRAIN;
        else if (capture)     state_d = cs_ni ? ST_DRAIN : ST_ACT;
      end
      ST_ACT:  state_d = ST_HOLD;
      ST_HOLD: begin
        if (!active_s) state_d = (rd_s_i || wr_s_i) ? ST_DRAIN : ST_IDLE;
      end
      ST_DRAIN: begin
        if (!rd_s_i && !wr_s_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      is_wr_q <= 1'b0;
      port_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (capture) begin
        is_wr_q <= wr_s_i;
        port_q  <= port_sel_i;
        addr_q  <= addr_i;
        wdata_q <= data_i;
      end
    end
  end

  assign state_o = state_q;
  assign is_wr_o = is_wr_q;
  assign port_o  = port_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign we_o    = (state_q == ST_ACT) &&  is_wr_q;
  assign re_o    = (state_q == ST_ACT) && !is_wr_q;
  assign rdy_o   = (state_q == ST_HOLD);
endmodule

// File: rtl/hreg_strobe_port.sv
module hreg_strobe_port
  import hreg_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              port_sel_i,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              rdy_oe_o
);
  logic [1:0]        strb_s;
  logic              rd_s, wr_s;
  hs_state_e         state;
  logic              is_wr, port, we, re;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata_q;
  logic [NUM_BANKS-1:0]  bank_we;
  logic [DATA_W-1:0]     bank_rdata [NUM_BANKS];

  hreg_sync2 #(.W(2)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({~wr_ni, ~rd_ni}),
    .q_o    (strb_s)
  );
  assign rd_s = strb_s[0];
  assign wr_s = strb_s[1];

  hreg_hs_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_s_i     (rd_s),
    .wr_s_i     (wr_s),
    .cs_ni      (cs_ni),
    .port_sel_i (port_sel_i),
    .addr_i     (addr_i),
    .data_i     (data_i),
    .state_o    (state),
    .is_wr_o    (is_wr),
    .port_o     (port),
    .addr_o     (acc_addr),
    .wdata_o    (wdata),
    .we_o       (we),
    .re_o       (re),
    .rdy_o      (rdy_oe_o)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_we[b] = we && (port == b[0]);
    hreg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (bank_we[b]),
      .addr_i  (acc_addr),
      .wdata_i (wdata),
      .rdata_o (bank_rdata[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (re)  rdata_q <= bank_rdata[port];
  end

  assign data_o    = rdata_q;
  // raw strobe and select gate the driver so release needs no clock edge
  assign data_oe_o = (state == ST_HOLD) && !is_wr && !rd_ni && !cs_ni;
endmodule

// File: rtl/hreg_strobe_port_chk.sv
module hreg_strobe_port_chk
  import hreg_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      rd_s,
  input logic      wr_s,
  input hs_state_e state,
  input logic      is_wr,
  input logic [1:0] bank_we,
  input logic      data_oe_o,
  input logic      rdy_oe_o
);
  a_r4_drive_within_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> rdy_oe_o);

  a_r7_ready_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_oe_o && (is_wr ? wr_s : rd_s)) |=> rdy_oe_o);

  a_r7_ready_from_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_oe_o) |-> $past(state == ST_ACT));

  a_r6_conflict_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE && rd_s && wr_s) |=> !rdy_oe_o);

  a_r2_one_bank_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_we));
endmodule

bind hreg_strobe_port hreg_strobe_port_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_s      (rd_s),
  .wr_s      (wr_s),
  .state     (state),
  .is_wr     (is_wr),
  .bank_we   (bank_we),
  .data_oe_o (data_oe_o),
  .rdy_oe_o  (rdy_oe_o)
);

// File: tb/test_hreg_strobe_port.sv
`timescale 1ns/1ps
module test_hreg_strobe_port;
  localparam int AW = 10;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cs_ni = 1'b1, port_sel_i = 1'b0, rd_ni = 1'b1, wr_ni = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic [DW-1:0] data_o;
  logic          data_oe_o, rdy_oe_o;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] mdl [2][1<<AW];

  always #2 clk = ~clk;

  hreg_strobe_port i_hreg_strobe_port (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .port_sel_i(port_sel_i),
    .rd_ni(rd_ni), .wr_ni(wr_ni), .addr_i(addr_i), .data_i(data_i),
    .data_o(data_o), .data_oe_o(data_oe_o), .rdy_oe_o(rdy_oe_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] expect_rd(input bit p, input logic [AW-1:0] a);
    return mdl[p][a];
  endfunction

  task automatic jitter();
    #($urandom_range(1, 3999) * 1ps);
  endtask

  task automatic wait_rdy(input bit want, input int max_cyc, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < max_cyc; i++) begin
      @(negedge clk);
      if (rdy_oe_o == want) begin seen = 1'b1; break; end
    end
  endtask

  // R3 R7 R9: write with full handshake
  task automatic host_write(input bit p, input logic [AW-1:0] a, input logic [DW-1:0] d);
    bit seen;
    jitter();
    cs_ni = 1'b0; port_sel_i = p; addr_i = a; data_i = d;
    jitter();
    wr_ni = 1'b0;
    wait_rdy(1'b1, 12, seen);
    check(seen, "R3 write ready", rdy_oe_o, 1);
    mdl[p][a] = d;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(rdy_oe_o == 1'b1, "R7 ready held", rdy_oe_o, 1);
    end
    addr_i = a ^ 10'h155; port_sel_i = ~p;  // R9 late change
    jitter();
    wr_ni = 1'b1;
    wait_rdy(1'b0, 6, seen);
    check(seen, "R7 ready release", rdy_oe_o, 0);
    cs_ni = 1'b1;
  endtask

  task automatic host_read(input bit p, input logic [AW-1:0] a);
    bit seen;
    logic [DW-1:0] exp = expect_rd(p, a);
    jitter();
    cs_ni = 1'b0; port_sel_i = p; addr_i = a;
    jitter();
    rd_ni = 1'b0;
    wait_rdy(1'b1, 12, seen);
    check(seen, "R4 read ready", rdy_oe_o, 1);
    check(data_oe_o == 1'b1, "R4 driver on at ready", data_oe_o, 1);
    check(data_o == exp, "R3 R2 read data", data_o, exp);
    addr_i = ~a; port_sel_i = ~p;  // R9 late change
    repeat (2) @(negedge clk);
    check(data_o == exp, "R9 data after addr change", data_o, exp);
    check(rdy_oe_o == 1'b1, "R7 ready held on read", rdy_oe_o, 1);
    jitter();
    rd_ni = 1'b1;
    #1ps;
    check(data_oe_o == 1'b0, "R8 immediate release", data_oe_o, 0);
    wait_rdy(1'b0, 6, seen);
    check(seen, "R7 read ready release", rdy_oe_o, 0);
    cs_ni = 1'b1;
  endtask

  task automatic quiet_window(input string req);
    int hits = 0;
    repeat (12) begin
      @(negedge clk);
      if (rdy_oe_o || data_oe_o) hits++;
    end
    check(hits == 0, req, hits, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd2024));
    for (int p = 0; p < 2; p++)
      for (int a = 0; a < (1<<AW); a++) mdl[p][a] = '0;
    repeat (3) @(negedge clk);
    check(rdy_oe_o == 1'b0, "R1 ready idle in reset", rdy_oe_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check(rdy_oe_o == 1'b0, "R1 ready idle", rdy_oe_o, 0);
    check(data_oe_o == 1'b0, "R1 driver off", data_oe_o, 0);
    host_read(1'b0, 10'h000);  // R1
    host_read(1'b1, 10'h3FF);  // R1

    // R2: same address, different banks
    host_write(1'b0, 10'h12A, 16'hA5A5);
    host_write(1'b1, 10'h12A, 16'h5A5A);
    host_read(1'b0, 10'h12A);
    host_read(1'b1, 10'h12A);
    // R9: late-changed address/bank must be untouched
    host_read(1'b1, 10'h12A ^ 10'h155);
    host_read(1'b0, 10'h12A ^ 10'h155);

    // R5: deselected write
    jitter();
    cs_ni = 1'b1; port_sel_i = 1'b0; addr_i = 10'h12A; data_i = 16'hFFFF;
    wr_ni = 1'b0;
    quiet_window("R5 no ready when deselected");
    wr_ni = 1'b1;
    repeat (4) @(negedge clk);
    host_read(1'b0, 10'h12A);  // R5 unchanged

    // R6: both strobes together
    jitter();
    cs_ni = 1'b0; port_sel_i = 1'b1; addr_i = 10'h12A; data_i = 16'h0BAD;
    rd_ni = 1'b0; wr_ni = 1'b0;
    quiet_window("R6 no ready on collision");
    rd_ni = 1'b1; wr_ni = 1'b1; cs_ni = 1'b1;
    repeat (4) @(negedge clk);
    host_read(1'b1, 10'h12A);  // R6 unchanged

    // boundary addresses, R3
    host_write(1'b0, 10'h3FF, 16'hFFFF);
    host_write(1'b1, 10'h000, 16'h0001);
    host_read(1'b0, 10'h3FF);
    host_read(1'b1, 10'h000);

    // random mix, R2 R3 R4
    for (int n = 0; n < 200; n++) begin
      bit p = 1'($urandom_range(0, 1));
      logic [AW-1:0] a = AW'($urandom_range(0, 15));
      if ($urandom_range(0, 1) == 0) host_write(p, a, DW'($urandom));
      else host_read(p, a);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule